// File: doc/BRIEF.md
# Saturating Doubling Multiply-High by Broadcast Scalar

This block decodes and executes one vector instruction. It multiplies each signed lane of a 64-bit or 128-bit source vector by a single element taken from a scalar register and copied to every lane. Each product is doubled and saturated, and the block returns the high half of the result. A rounding variant adds the top bit of the discarded low half before it returns the high half. Lanes are 16 or 32 bits wide, chosen by the size field of the instruction.

The block takes the instruction word and a valid strobe. It drives three read addresses towards an external register file of 64-bit registers and receives the read data back in the same cycle. One cycle later it presents the following registered outputs:
- the destination register number, its width and the result vector, for a defined instruction;
- an undefined-instruction pulse, for an encoding it recognises but rejects.

A sticky flag records any lane that saturated. The flag holds until an external clear pulse.

Top module: `simd_qdmulh_scalar`

## Requirements
- R1: A word is recognised only when bits 31:25 are 1111001, bit 23 is 1, bit 6 is 1, bit 4 is 0 and bits 11:9 are 110. Bit 8 selects the rounding form (1) or the plain form (0). A strobed word that is not recognised raises neither `out_valid` nor `out_undef` in the next cycle.
- R2: A recognised word whose size field (bits 21:20) is 00 or 11 raises `out_undef` for one cycle after the strobe. It does not raise `out_valid` and leaves the sticky flag unchanged. `out_valid` and `out_undef` are never high together.
- R3: When the quad bit (bit 24) is 1 and bit 12 or bit 16 of the word is 1, the word is undefined in the same way as R2.
- R4: The field layout is as follows: Vn in bits 19:16, Vd in bits 15:12, N in bit 7, M in bit 5, Vm in bits 3:0, D in bit 22. The low source address is {N,Vn} and the high source address is {N,Vn[3:1],1}. The scalar address is {00,Vm[2:0]} for size 01 and {0,Vm} for size 10. All three addresses are combinational from the word.
- R5: Size 01 gives 16-bit lanes and the scalar element index is {M,Vm[3]}. Size 10 gives 32-bit lanes and the index is M. Element k occupies bits k*width upward of the scalar register. It is applied to every lane.
- R6: In the plain form each lane result is bits 2w-1:w of twice the signed product of the two lane values, where w is the lane width.
- R7: In the rounding form, bit w-1 of the doubled product is added to that upper half.
- R8: A lane whose two inputs are both the most negative value yields the most positive value in both forms. When that lane is active in a defined instruction, `sat_sticky` is set in the cycle the result appears.
- R9: A `sat_clr` pulse clears `sat_sticky` at the next edge. If a saturating result is registered at that same edge, the flag ends up set.
- R10: A defined instruction raises `out_valid` exactly one cycle after the strobe. `out_dst` is {D,Vd} and `out_quad` is the quad bit. In the quad form the low 64 result bits come from the low source register and the high 64 bits from the high source register. In the 64-bit form, bits 127:64 of `out_data` are zero.
- R11: During reset `out_valid`, `out_undef` and `sat_sticky` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction strobe |
| in_instr | input | 32 | Instruction word |
| sat_clr | input | 1 | Clears the sticky saturation flag |
| rf_src_lo_addr | output | 5 | Read address, low 64 bits of first source |
| rf_src_hi_addr | output | 5 | Read address, high 64 bits of first source |
| rf_scl_addr | output | 5 | Read address, scalar register |
| rf_src_lo_data | input | 64 | Read data for rf_src_lo_addr |
| rf_src_hi_data | input | 64 | Read data for rf_src_hi_addr |
| rf_scl_data | input | 64 | Read data for rf_scl_addr |
| out_valid | output | 1 | Registered result is valid |
| out_undef | output | 1 | Recognised but undefined instruction |
| out_quad | output | 1 | Result is 128 bits wide |
| out_dst | output | 5 | Destination register number |
| out_data | output | 128 | Result vector |
| sat_sticky | output | 1 | Sticky saturation flag |

## Verification
The assertions assume that the register file returns its read data in the same cycle as the addresses, which the bench models with a combinational array. They also assume that `sat_clr` is the only way the flag falls. The random stimulus builds only recognised words with legal sizes and even quad register numbers. In about one operation in five it loads most-negative patterns into the operands so that saturation is exercised. Undefined sizes, odd quad registers, unrecognised words and simultaneous clear-and-set are exercised as directed cases.

// File: rtl/simd_qdmulh_pkg.sv
package simd_qdmulh_pkg;
  localparam int unsigned DREG_W  = 64;
  localparam int unsigned NUM_REG = 32;
  localparam int unsigned RADDR_W = $clog2(NUM_REG);
  localparam int unsigned VEC_W   = 2 * DREG_W;
  localparam int unsigned INSTR_W = 32;

  typedef struct packed {
    logic               hit;      // recognised encoding
    logic               undef;    // recognised but rejected
    logic               quad;     // 128-bit operation
    logic               rnd;      // rounding form
    logic               wide;     // 32-bit lanes
    logic [RADDR_W-1:0] dst;
    logic [RADDR_W-1:0] src_lo;
    logic [RADDR_W-1:0] src_hi;
    logic [RADDR_W-1:0] scl;
    logic [1:0]         idx;
  } qdm_dec_t;
endpackage

// File: rtl/qdm_decode.sv
module qdm_decode
  import simd_qdmulh_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output qdm_dec_t           dec_o
);
  logic       f_q, f_d, f_n, f_m;
  logic [1:0] f_sz;
  logic [3:0] f_vn, f_vd, f_vm;
  logic       pattern_ok;
  logic       bad_size;
  logic       bad_align;

  always_comb begin
    f_q  = instr_i[24];
    f_d  = instr_i[22];
    f_sz = instr_i[21:20];
    f_vn = instr_i[19:16];
    f_vd = instr_i[15:12];
    f_n  = instr_i[7];
    f_m  = instr_i[5];
    f_vm = instr_i[3:0];

    pattern_ok = (instr_i[31:25] == 7'b1111001) && instr_i[23] &&
                 instr_i[6] && !instr_i[4] && (instr_i[11:9] == 3'b110);
    bad_size   = (f_sz == 2'b00) || (f_sz == 2'b11);
    bad_align  = f_q && (f_vd[0] || f_vn[0]);
  end

  always_comb begin
    dec_o        = '0;
    dec_o.hit    = pattern_ok;
    dec_o.undef  = pattern_ok && (bad_size || bad_align);
    dec_o.quad   = f_q;
    dec_o.rnd    = instr_i[8];
    dec_o.wide   = f_sz[1];
    dec_o.dst    = {f_d, f_vd};
    dec_o.src_lo = {f_n, f_vn};
    dec_o.src_hi = {f_n, f_vn[3:1], 1'b1};
    if (f_sz[1]) begin
      dec_o.scl = {1'b0, f_vm};
      dec_o.idx = {1'b0, f_m};
    end else begin
      dec_o.scl = {2'b00, f_vm[2:0]};
      dec_o.idx = {f_m, f_vm[3]};
    end
  end
endmodule

// File: rtl/qdm_scalar_pick.sv
module qdm_scalar_pick #(
  parameter int unsigned DW = 64
) (
  input  logic [DW-1:0] data_i,
  input  logic [1:0]    idx_i,
  output logic [15:0]   half_o,
  output logic [31:0]   word_o
);
  localparam int unsigned N_HALF = DW / 16;
  localparam int unsigned N_WORD = DW / 32;

  logic [15:0] halves [N_HALF];
  logic [31:0] words  [N_WORD];

  for (genvar h = 0; h < N_HALF; h++) begin : g_half
    assign halves[h] = data_i[h*16 +: 16];
  end
  for (genvar w = 0; w < N_WORD; w++) begin : g_word
    assign words[w] = data_i[w*32 +: 32];
  end

  always_comb begin
    half_o = halves[idx_i];
    word_o = words[idx_i[0]];
  end
endmodule

// File: rtl/qdm_lane.sv
module qdm_lane #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         rnd_i,
  output logic [W-1:0] res_o,
  output logic         sat_o
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

  logic signed [2*W-1:0] a_x, b_x, prod;
  logic        [W:0]     upr;      // doubled-product bits 2W-1 .. W-1
  logic        [W-1:0]   hi;
  logic                  rbit;

  always_comb begin
    a_x   = {{W{a_i[W-1]}}, a_i};
    b_x   = {{W{b_i[W-1]}}, b_i};
    prod  = a_x * b_x;
    upr   = (W+1)'(prod >> (W-2));
    hi    = upr[W:1];
    rbit  = rnd_i & upr[0];
    sat_o = (a_i == MOST_NEG) && (b_i == MOST_NEG);
    if (sat_o) res_o = MOST_POS;
    else       res_o = hi + {{(W-1){1'b0}}, rbit};
  end
endmodule

// File: rtl/simd_qdmulh_scalar.sv
module simd_qdmulh_scalar
  import simd_qdmulh_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [INSTR_W-1:0] in_instr,
  input  logic               sat_clr,
  output logic [RADDR_W-1:0] rf_src_lo_addr,
  output logic [RADDR_W-1:0] rf_src_hi_addr,
  output logic [RADDR_W-1:0] rf_scl_addr,
  input  logic [DREG_W-1:0]  rf_src_lo_data,
  input  logic [DREG_W-1:0]  rf_src_hi_data,
  input  logic [DREG_W-1:0]  rf_scl_data,
  output logic               out_valid,
  output logic               out_undef,
  output logic               out_quad,
  output logic [RADDR_W-1:0] out_dst,
  output logic [VEC_W-1:0]   out_data,
  output logic               sat_sticky
);
  localparam int unsigned L16 = VEC_W / 16;
  localparam int unsigned L32 = VEC_W / 32;

  qdm_dec_t dec;
  qdm_decode u_dec (.instr_i(in_instr), .dec_o(dec));

  assign rf_src_lo_addr = dec.src_lo;
  assign rf_src_hi_addr = dec.src_hi;
  assign rf_scl_addr    = dec.scl;

  logic [15:0] scl16;
  logic [31:0] scl32;
  qdm_scalar_pick #(.DW(DREG_W)) u_pick (
    .data_i (rf_scl_data),
    .idx_i  (dec.idx),
    .half_o (scl16),
    .word_o (scl32)
  );

  logic [VEC_W-1:0] vec_a;
  assign vec_a = dec.quad ? {rf_src_hi_data, rf_src_lo_data}
                          : {{DREG_W{1'b0}}, rf_src_lo_data};

  logic [VEC_W-1:0] res16, res32;
  logic [L16-1:0]   sat16, act16;
  logic [L32-1:0]   sat32, act32;

  for (genvar i = 0; i < L16; i++) begin : g_l16
    qdm_lane #(.W(16)) u_lane (
      .a_i   (vec_a[i*16 +: 16]),
      .b_i   (scl16),
      .rnd_i (dec.rnd),
      .res_o (res16[i*16 +: 16]),
      .sat_o (sat16[i])
    );
    assign act16[i] = dec.quad || (i < L16/2);
  end

  for (genvar j = 0; j < L32; j++) begin : g_l32
    qdm_lane #(.W(32)) u_lane (
      .a_i   (vec_a[j*32 +: 32]),
      .b_i   (scl32),
      .rnd_i (dec.rnd),
      .res_o (res32[j*32 +: 32]),
      .sat_o (sat32[j])
    );
    assign act32[j] = dec.quad || (j < L32/2);
  end

  // next-state logic
  logic             fire, load;
  logic             sat_any;
  logic [VEC_W-1:0] res_sel;
  logic             valid_d, undef_d, sticky_d;

  always_comb begin
    fire     = in_valid && dec.hit;
    load     = fire && !dec.undef;
    sat_any  = dec.wide ? |(sat32 & act32) : |(sat16 & act16);
    res_sel  = dec.wide ? res32 : res16;
    if (!dec.quad) res_sel[VEC_W-1:DREG_W] = '0;
    valid_d  = load;
    undef_d  = fire && dec.undef;
    sticky_d = (sat_sticky && !sat_clr) || (load && sat_any);
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_undef  <= 1'b0;
      sat_sticky <= 1'b0;
    end else begin
      out_valid  <= valid_d;
      out_undef  <= undef_d;
      sat_sticky <= sticky_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_quad <= 1'b0;
      out_dst  <= '0;
      out_data <= '0;
    end else if (load) begin
      out_quad <= dec.quad;
      out_dst  <= dec.dst;
      out_data <= res_sel;
    end
  end
endmodule

// File: rtl/simd_qdmulh_scalar_chk.sv
module simd_qdmulh_scalar_chk #(
  parameter int unsigned VEC_W   = 128,
  parameter int unsigned RADDR_W = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               sat_clr,
  input logic               out_valid,
  input logic               out_undef,
  input logic               out_quad,
  input logic [RADDR_W-1:0] out_dst,
  input logic [VEC_W-1:0]   out_data,
  input logic               sat_sticky
);
  assert_valid_undef_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_undef));

  assert_undef_after_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_undef |-> $past(in_valid));

  assert_quad_dst_even_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_quad) |-> ((out_dst & RADDR_W'(1)) == '0));

  assert_valid_after_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  assert_dform_upper_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_quad) |-> ((out_data >> (VEC_W/2)) == '0));

  assert_sticky_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sat_sticky) |-> out_valid);

  assert_sticky_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sat_sticky) |-> $past(sat_clr));
endmodule

bind simd_qdmulh_scalar simd_qdmulh_scalar_chk #(
  .VEC_W   (simd_qdmulh_pkg::VEC_W),
  .RADDR_W (simd_qdmulh_pkg::RADDR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .sat_clr    (sat_clr),
  .out_valid  (out_valid),
  .out_undef  (out_undef),
  .out_quad   (out_quad),
  .out_dst    (out_dst),
  .out_data   (out_data),
  .sat_sticky (sat_sticky)
);

// File: tb/simd_qdmulh_scalar_bench.sv
module simd_qdmulh_scalar_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [31:0]  in_instr;
  logic         sat_clr;
  logic [4:0]   lo_addr, hi_addr, scl_addr;
  logic [63:0]  lo_data, hi_data, scl_data;
  logic         out_valid, out_undef, out_quad, sat_sticky;
  logic [4:0]   out_dst;
  logic [127:0] out_data;

  logic [63:0] rf [32];
  int checks = 0;
  int fails  = 0;
  logic exp_sticky = 1'b0;

  always #10 clk = ~clk;

  assign lo_data  = rf[lo_addr];
  assign hi_data  = rf[hi_addr];
  assign scl_data = rf[scl_addr];

  simd_qdmulh_scalar u_simd_qdmulh_scalar (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
    .sat_clr(sat_clr), .rf_src_lo_addr(lo_addr), .rf_src_hi_addr(hi_addr),
    .rf_scl_addr(scl_addr), .rf_src_lo_data(lo_data), .rf_src_hi_data(hi_data),
    .rf_scl_data(scl_data), .out_valid(out_valid), .out_undef(out_undef),
    .out_quad(out_quad), .out_dst(out_dst), .out_data(out_data),
    .sat_sticky(sat_sticky)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic q, d, input logic [1:0] sz,
      input logic [3:0] vn, vd, input logic n, m, input logic [3:0] vm, input logic rnd);
    return {7'b1111001, q, 1'b1, d, sz, vn, vd, 3'b110, rnd, n, 1'b1, m, 1'b0, vm};
  endfunction

  function automatic logic [31:0] lane_ref(input int w, input logic [31:0] a, b,
      input logic rnd, output logic sat);
    longint sa, sb, p, minv, up;
    logic [63:0] pu;
    sa   = (w == 16) ? longint'($signed(a[15:0])) : longint'($signed(a));
    sb   = (w == 16) ? longint'($signed(b[15:0])) : longint'($signed(b));
    minv = -(longint'(1) <<< (w-1));
    sat  = (sa == minv) && (sb == minv);
    if (sat) return 32'((longint'(1) <<< (w-1)) - 1);
    p  = 2 * sa * sb;
    up = p >>> w;
    pu = 64'(p);
    if (rnd) up = up + longint'(pu[w-1]);
    return 32'(up);
  endfunction

  function automatic logic [127:0] ref_calc(input logic [31:0] ins, output logic sat);
    logic q, rnd, s;
    logic [127:0] va, r;
    logic [63:0] sreg;
    logic [31:0] sc;
    int nl;
    q    = ins[24];
    rnd  = ins[8];
    va   = q ? {rf[{ins[7], ins[19:17], 1'b1}], rf[{ins[7], ins[19:16]}]}
             : {64'b0, rf[{ins[7], ins[19:16]}]};
    r    = '0;
    sat  = 1'b0;
    if (ins[21:20] == 2'b01) begin
      sreg = rf[{2'b00, ins[2:0]}];
      sc   = {16'b0, sreg[{ins[5], ins[3]}*16 +: 16]};
      nl   = q ? 8 : 4;
      for (int k = 0; k < nl; k++) begin
        r[k*16 +: 16] = lane_ref(16, {16'b0, va[k*16 +: 16]}, sc, rnd, s)[15:0];
        sat |= s;
      end
    end else begin
      sreg = rf[{1'b0, ins[3:0]}];
      sc   = sreg[ins[5]*32 +: 32];
      nl   = q ? 4 : 2;
      for (int k = 0; k < nl; k++) begin
        r[k*32 +: 32] = lane_ref(32, va[k*32 +: 32], sc, rnd, s);
        sat |= s;
      end
    end
    return r;
  endfunction

  // kind: 0 defined, 1 undefined, 2 unrecognised
  task automatic run_op(input logic [31:0] ins, input int kind, input logic clr, input string req);
    logic [127:0] exp_d;
    logic s;
    @(negedge clk);
    in_valid = 1'b1;
    in_instr = ins;
    sat_clr  = clr;
    #1;
    if (kind == 0) begin
      check("R4 lo addr", 128'(lo_addr), 128'({ins[7], ins[19:16]}));
      check("R4 hi addr", 128'(hi_addr), 128'({ins[7], ins[19:17], 1'b1}));
      check("R4 scl addr", 128'(scl_addr),
            ins[21] ? 128'({1'b0, ins[3:0]}) : 128'({2'b00, ins[2:0]}));
    end
    exp_d = ref_calc(ins, s);
    exp_sticky = (exp_sticky && !clr) || (kind == 0 && s);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    sat_clr  = 1'b0;
    check({req, " R10 valid"}, 128'(out_valid), 128'(kind == 0));
    check({req, " R2 undef"}, 128'(out_undef), 128'(kind == 1));
    check({req, " R8/R9 sticky"}, 128'(sat_sticky), 128'(exp_sticky));
    if (kind == 0) begin
      check({req, " data"}, out_data, exp_d);
      check("R10 dst", 128'(out_dst), 128'({ins[22], ins[15:12]}));
      check("R10 quad", 128'(out_quad), 128'(ins[24]));
    end
  endtask

  initial begin
    #(20 * 20000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd1234);
    for (int i = 0; i < 32; i++) rf[i] = {$urandom, $urandom};
    rst_n = 1'b0; in_valid = 1'b0; in_instr = '0; sat_clr = 1'b0;
    repeat (3) @(negedge clk);
    check("R11 valid reset", 128'(out_valid), 128'(0));
    check("R11 undef reset", 128'(out_undef), 128'(0));
    check("R11 sticky reset", 128'(sat_sticky), 128'(0));
    rst_n = 1'b1;

    // directed: undefined and unrecognised encodings
    run_op(mk(0,0,2'b00,4'd1,4'd2,0,0,4'd3,0), 1, 0, "R2 sz00");
    run_op(mk(1,0,2'b11,4'd2,4'd4,0,0,4'd3,1), 1, 0, "R2 sz11");
    run_op(mk(1,1,2'b01,4'd2,4'd5,0,1,4'd3,0), 1, 0, "R3 odd Vd");
    run_op(mk(1,0,2'b10,4'd3,4'd4,1,0,4'd3,0), 1, 0, "R3 odd Vn");
    run_op(mk(0,0,2'b01,4'd1,4'd2,0,0,4'd3,0) & ~32'h0000_0040, 2, 0, "R1 bit6 clear");
    run_op(mk(0,0,2'b01,4'd1,4'd2,0,0,4'd3,0) ^ 32'h0000_0400, 2, 0, "R1 opc bits");

    // directed: saturation, plain and rounding, 16 and 32 bit
    rf[4] = 64'h8000_8000_8000_8000; rf[5] = 64'h8000_8000_8000_8000;
    rf[2] = 64'h8000_8000_8000_8000;
    run_op(mk(1,0,2'b01,4'd4,4'd6,0,1,4'd2,0), 0, 0, "R8 sat16 plain");
    run_op(mk(0,0,2'b01,4'd4,4'd7,0,0,4'd2,1), 0, 1, "R9 clear+set R8 rnd");
    run_op(mk(0,0,2'b10,4'd9,4'd1,0,0,4'd9,1), 0, 1, "R9 clear");
    rf[8] = 64'h8000_0000_8000_0000; rf[9] = 64'h8000_0000_8000_0000;
    run_op(mk(1,0,2'b10,4'd8,4'd0,0,1,4'd8,1), 0, 0, "R8 sat32 rnd");
    run_op(mk(0,0,2'b10,4'd1,4'd1,0,0,4'd2,0), 0, 1, "R9 clear2");
    // rounding bit: 0x4000*0x0001 doubled = 0x8000 -> low bit15 set
    rf[10] = 64'h0000_0000_0000_4000; rf[3] = 64'h0000_0000_0000_0001;
    run_op(mk(0,0,2'b01,4'd10,4'd3,0,0,4'd3,1), 0, 0, "R7 round up");
    run_op(mk(0,0,2'b01,4'd10,4'd3,0,0,4'd3,0), 0, 0, "R6 no round");

    // random legal operations
    for (int it = 0; it < 400; it++) begin
      logic q, rnd, n, m, d;
      logic [1:0] sz;
      logic [3:0] vn, vd, vm;
      logic [31:0] ins;
      q = 1'($urandom); rnd = 1'($urandom); n = 1'($urandom);
      m = 1'($urandom); d = 1'($urandom);
      sz = ($urandom % 2 == 0) ? 2'b01 : 2'b10;
      vn = 4'($urandom); vd = 4'($urandom); vm = 4'($urandom);
      if (q) begin vn[0] = 1'b0; vd[0] = 1'b0; end
      ins = mk(q, d, sz, vn, vd, n, m, vm, rnd);
      if (it % 7 == 0) for (int i = 0; i < 32; i++) rf[i] = {$urandom, $urandom};
      if ($urandom % 5 == 0) begin
        logic [63:0] pat;
        pat = (sz == 2'b01) ? 64'h8000_8000_8000_8000 : 64'h8000_0000_8000_0000;
        rf[{n, vn}] = pat; rf[{n, vn[3:1], 1'b1}] = pat;
        rf[(sz == 2'b01) ? {2'b00, vm[2:0]} : {1'b0, vm}] = pat;
      end
      run_op(ins, 0, ($urandom % 6 == 0), rnd ? "R5 R7 random" : "R5 R6 random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule